// File: doc/BRIEF.md
# Pixel Row/Tile Packing Converter

This block regroups 8-bit pixels as they stream between a memory port and a processing unit. Two packings are involved. A *row word* holds four pixels that sit side by side on one image row. A *tile word* holds the four pixels of a 2×2 square. Software never shuffles bytes itself: the stream passes through this unit and comes out in the other packing. Pixels are neither lost nor changed.

The input stream arrives as word pairs. For row input, a pair is the row-r word followed by the row-r+1 word covering the same four columns. For tile input, a pair is the tile for columns 0–1 followed by the tile for columns 2–3. Each pair produces exactly two output words. The regrouping is a transpose of 2×2 lane blocks, and that transpose is its own inverse. One lane network therefore serves both directions, and no direction pin is needed. The unit holds the first word of a pair until the second arrives.

Both stream sides use valid/ready. A word moves on a rising clock edge where valid and ready are both high. Once `out_valid` is raised, `out_valid` and `out_data` stay fixed until the word is taken. `in_ready` falls only when a first word is already held and the previous output pair cannot finish draining in the same cycle. With `out_ready` held high, the unit accepts one word per cycle indefinitely.

Top module: `pix_tile_reformatter`

## Requirements
- R1: While reset is applied and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Row pair (A, B) gives a first output with lanes, from bits [7:0] upward: A0, A1, B0, B1 (top-left, top-right, bottom-left, bottom-right). Lane k occupies bits [8k+7:8k].
- R3: The second output of a row pair covers columns 2–3, with lanes A2, A3, B2, B3.
- R4: Tile pair (T, U) gives rows: first output lanes T0, T1, U0, U1, and second output lanes T2, T3, U2, U3.
- R5: Feeding the two outputs of a pair back in reproduces the original pair exactly, in order.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` do not change.
- R7: With output stalled, the unit holds at most one output pair plus one waiting input word, and `in_ready` is 0 in that state.
- R8: With `out_ready` held at 1 and input offered every cycle, `in_ready` never drops.
- R9: Each accepted pair produces exactly two outputs, first word then second, in arrival order. The count of words out never exceeds the count in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Unit can take the input word |
| in_data | input | 32 | Row or tile word, lane k at bits [8k+7:8k] |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Regrouped word |

## Verification
The hardest state to reach from the ports is a full stall: an output pair blocked, a first word held, and a further word waiting at the input. The bench reaches it by holding `out_ready` low while pushing three words. It then checks `in_ready`, and releases the output. Random gaps on both valid and ready exercise the state where a new pair is accepted in the same cycle the last output word leaves. A separate zero-gap burst confirms that throughput never drops below one word per cycle.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned TILE_SIDE = 2;

  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;
endpackage

// File: rtl/tf_pair_gather.sv
module tf_pair_gather #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              pair_free,
  output logic              pair_fire,
  output logic [WORD_W-1:0] first_word,
  output logic [WORD_W-1:0] second_word
);
  logic              held_v;
  logic [WORD_W-1:0] held_q;
  logic              take;

  assign in_ready    = !held_v || pair_free;
  assign take        = in_valid && in_ready;
  assign pair_fire   = take && held_v;
  assign first_word  = held_q;
  assign second_word = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held_q <= '0;
    end else if (take) begin
      if (held_v) begin
        held_v <= 1'b0;
      end else begin
        held_v <= 1'b1;
        held_q <= in_data;
      end
    end
  end
endmodule

// File: rtl/tf_lane_xpose.sv
module tf_lane_xpose #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [tf_pkg::LANES*PIX_W-1:0] upper_w,
  input  logic [tf_pkg::LANES*PIX_W-1:0] lower_w,
  output logic [tf_pkg::LANES*PIX_W-1:0] res0_w,
  output logic [tf_pkg::LANES*PIX_W-1:0] res1_w
);
  localparam int unsigned S = tf_pkg::TILE_SIDE;
  localparam int unsigned W = tf_pkg::LANES * PIX_W;

  logic [S-1:0][W-1:0] res_arr;

  // Block j of the result takes lanes 2j,2j+1 of the upper word,
  // then lanes 2j,2j+1 of the lower word.
  for (genvar j = 0; j < S; j++) begin : g_blk
    for (genvar c = 0; c < S; c++) begin : g_col
      assign res_arr[j][c*PIX_W +: PIX_W] =
        upper_w[(S*j + c)*PIX_W +: PIX_W];
      assign res_arr[j][(S + c)*PIX_W +: PIX_W] =
        lower_w[(S*j + c)*PIX_W +: PIX_W];
    end
  end

  assign res0_w = res_arr[0];
  assign res1_w = res_arr[1];
endmodule

// File: rtl/tf_out_seq.sv
module tf_out_seq #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_fire,
  input  logic [WORD_W-1:0] res0_w,
  input  logic [WORD_W-1:0] res1_w,
  output logic              pair_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  import tf_pkg::*;

  slot_e             slot_q;
  logic              vld_q;
  logic [WORD_W-1:0] w0_q, w1_q;

  assign pair_free = !vld_q || (slot_q == SLOT_SECOND && out_ready);
  assign out_valid = vld_q;
  assign out_data  = (slot_q == SLOT_SECOND) ? w1_q : w0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      slot_q <= SLOT_FIRST;
      w0_q   <= '0;
      w1_q   <= '0;
    end else if (pair_fire) begin
      vld_q  <= 1'b1;
      slot_q <= SLOT_FIRST;
      w0_q   <= res0_w;
      w1_q   <= res1_w;
    end else if (vld_q && out_ready) begin
      if (slot_q == SLOT_FIRST) begin
        slot_q <= SLOT_SECOND;
      end else begin
        vld_q  <= 1'b0;
        slot_q <= SLOT_FIRST;
      end
    end
  end
endmodule

// File: rtl/pix_tile_reformatter.sv
module pix_tile_reformatter #(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned WORD_W = tf_pkg::LANES * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic              pair_free, pair_fire;
  logic [WORD_W-1:0] first_word, second_word, res0_w, res1_w;

  tf_pair_gather #(.WORD_W(WORD_W)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pair_free(pair_free), .pair_fire(pair_fire),
    .first_word(first_word), .second_word(second_word)
  );

  tf_lane_xpose #(.PIX_W(PIX_W)) u_xpose (
    .upper_w(first_word), .lower_w(second_word),
    .res0_w(res0_w), .res1_w(res1_w)
  );

  tf_out_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .pair_fire(pair_fire), .res0_w(res0_w), .res1_w(res1_w),
    .pair_free(pair_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/pix_tile_reformatter_chk.sv
module pix_tile_reformatter_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);
  logic [2:0] occ_q;
  logic       in_hs, out_hs;

  assign in_hs  = in_valid && in_ready;
  assign out_hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + {2'b0, in_hs} - {2'b0, out_hs};
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R6
  a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  // R7, R9: occupancy never above one pair plus one word, never negative
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 3'd3);

  // R7: full stall refuses input
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == 3'd3) && !out_ready |-> !in_ready);
endmodule

bind pix_tile_reformatter pix_tile_reformatter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/pix_tile_reformatter_test.sv
module pix_tile_reformatter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int tests = 0;
  int fails = 0;
  int rnd_ready = 0;
  int seen = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_out[2];
  logic [31:0] prev_data;
  logic        prev_stall = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_tile_reformatter uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] ln(logic [31:0] w, int k);
    return w[k*8 +: 8];
  endfunction

  // Expected regrouping from R2/R3/R4
  function automatic logic [31:0] grp(logic [31:0] a, logic [31:0] b, int blk);
    return {ln(b, 2*blk+1), ln(b, 2*blk), ln(a, 2*blk+1), ln(a, 2*blk)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) check("R6", {31'b0, out_valid} ^ 32'h1 | {out_data ^ prev_data}, 32'h0);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R9", out_data, 32'hxxxx_xxxx);
        end else begin
          check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
        last_out[seen % 2] = out_data;
        seen++;
      end
    end
  end

  always @(posedge clk) begin
    if (rnd_ready != 0) begin
      #1 out_ready = ($urandom % 3) != 0;
    end
  end

  task automatic send(logic [31:0] w, int gap);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int i = 0; i < gap; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic send_pair(logic [31:0] a, logic [31:0] b, string t0, string t1, int gap);
    exp_q.push_back(grp(a, b, 0)); tag_q.push_back(t0);
    exp_q.push_back(grp(a, b, 1)); tag_q.push_back(t1);
    send(a, gap);
    send(b, gap);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    check("R9", 32'(exp_q.size()), 32'd0);
    #1;
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {30'b0, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {30'b0, out_valid, in_ready}, 32'h1);
    @(posedge clk); #1;

    // Directed row pair: R2, R3
    out_ready = 1'b1;
    send_pair(32'h33221100, 32'h77665544, "R2", "R3", 0);
    drain();
    check("R2", last_out[0], 32'h55441100);
    check("R3", last_out[1], 32'h77663322);

    // R5: feed outputs back, expect the original rows
    begin
      logic [31:0] t0, t1;
      t0 = last_out[0]; t1 = last_out[1];
      exp_q.push_back(32'h33221100); tag_q.push_back("R5");
      exp_q.push_back(32'h77665544); tag_q.push_back("R5");
      send(t0, 0);
      send(t1, 0);
      drain();
    end

    // R4: directed tile pair
    send_pair(32'hD3D2D1D0, 32'hE3E2E1E0, "R4", "R4", 1);
    drain();
    check("R4", last_out[0], 32'hE1E0D1D0);

    // R7: stall output, push three words
    out_ready = 1'b0;
    exp_q.push_back(grp(32'h0A0B0C0D, 32'h1A1B1C1D, 0)); tag_q.push_back("R7");
    exp_q.push_back(grp(32'h0A0B0C0D, 32'h1A1B1C1D, 1)); tag_q.push_back("R7");
    send(32'h0A0B0C0D, 0);
    send(32'h1A1B1C1D, 0);
    send(32'h2A2B2C2D, 0);
    in_valid = 1'b1; in_data = 32'h3A3B3C3D;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7", {30'b0, out_valid, in_ready}, 32'h2);
    exp_q.push_back(grp(32'h2A2B2C2D, 32'h3A3B3C3D, 0)); tag_q.push_back("R7");
    exp_q.push_back(grp(32'h2A2B2C2D, 32'h3A3B3C3D, 1)); tag_q.push_back("R7");
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();

    // R8: zero-gap burst with sink always ready
    begin
      int stalls = 0;
      for (int p = 0; p < 8; p++) begin
        logic [31:0] a, b;
        a = $urandom; b = $urandom;
        exp_q.push_back(grp(a, b, 0)); tag_q.push_back("R8");
        exp_q.push_back(grp(a, b, 1)); tag_q.push_back("R8");
        for (int k = 0; k < 2; k++) begin
          in_valid = 1'b1;
          in_data  = (k == 0) ? a : b;
          @(negedge clk);
          if (!in_ready) stalls++;
          while (!in_ready) @(negedge clk);
          @(posedge clk); #1;
        end
      end
      in_valid = 1'b0;
      check("R8", 32'(stalls), 32'd0);
      drain();
    end

    // Random traffic with random back-pressure: R2, R3, R6, R9
    rnd_ready = 1;
    for (int p = 0; p < 60; p++) begin
      send_pair($urandom, $urandom, "R2", "R3", $urandom % 3);
    end
    drain();
    rnd_ready = 0;
    #1 out_ready = 1'b1;
    check("R9", 32'(seen), 32'd2 * (1 + 1 + 1 + 2 + 8 + 60));
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule